// File: doc/BRIEF.md
# Chained Indirect Effective-Address Resolver

The resolver turns the first address word of an instruction into a final effective address. Each address word holds an address field, a selector naming one of the index registers, and an indirection flag. The flag marks the word as a pointer rather than a final address. At every level the engine adds the selected index register to the address field. If the word is a pointer, the engine reads the addressed memory word and decodes that word next. The walk ends at the first word without the flag. The engine then presents the effective address together with a one-cycle done strobe.

A small window of low memory can be set up as self-modifying pointers. When the walk reaches such a location as a pointer, the engine adjusts the low address field of the word it read by one, writes the word back, and then decodes the adjusted word. Two window layouts are selectable, and so is a setting with no window. Because a chain can point back at itself, the interrupt request is sampled before every word is decoded. A pending request ends the walk with an abort strobe. The caller restarts the instruction from its first word. Memory writes made before the abort stay in memory.

Top module: `chain_addr_resolver`

## Requirements
- R1: Address word format: bit 35 is the indirection flag, bits 20:18 select an index register and bits 17:0 hold the address. The address of a word is bits 17:0 plus index register `sel`, modulo 2^18, for `sel` 1 to 7. `sel` = 0 adds nothing.
- R2: `start` is taken only when the engine is idle. If the first word is direct, `done` rises and `ea` carries the address in the cycle after the start edge, with no memory request.
- R3: Index addition is applied to the word decoded at every level, not only to the first word.
- R4: A word with the flag set causes one read of its computed address. The word returned becomes the next word decoded.
- R5: With `aix_mode` = 1, a pointer address in 8..15 is an incrementing location.
- R6: With `aix_mode` = 2, pointer addresses 16..23 increment and 24..31 decrement. With `aix_mode` = 0 or 3 no location is modified.
- R7: For a modified location, bits 17:0 of the word read move by +1 or -1 with wrap-around, and bits 35:18 are unchanged. This word is written to the same address by the next request, and is then decoded. A final (direct) address inside a window is neither read nor written.
- R8: `irq` is sampled before every decode, including the first. When set, `abort` pulses for one cycle, `done` stays low, and no further memory request is made.
- R9: Writes completed before an abort persist. A restarted walk observes them.
- R10: At most one memory request is active. `mem_addr`, `mem_we` and `mem_wdata` hold steady until `mem_rdy` is sampled high. A request that is granted after w wait cycles occupies 1+w cycles.
- R11: `done` and `abort` are single-cycle pulses and never coincide. `ea` changes only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk with `first_word` |
| first_word | input | 36 | First address word of the instruction |
| idx_regs | input | 126 | Index registers 1..7, register k at bits (k-1)*18 upward |
| aix_mode | input | 2 | Self-modifying window layout: 0/3 none, 1 low window, 2 split window |
| irq | input | 1 | Interrupt request |
| mem_req | output | 1 | Memory request active |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 18 | Request address |
| mem_wdata | output | 36 | Write data |
| mem_rdata | input | 36 | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Request completes at this edge |
| ea | output | 18 | Resolved effective address |
| done | output | 1 | One-cycle pulse: `ea` is valid |
| abort | output | 1 | One-cycle pulse: walk abandoned for an interrupt |

## Verification
With w memory wait cycles, a walk through L pointer levels, of which A hit a modifying location, ends with `done` visible 1 + L*(2+w) + A*(1+w) cycles after the start edge. An abort appears at the first decode edge after the `irq` change. The bench model steps through the chain with integers to predict the exact ending cycle. Each clock it checks that `done` and `abort` stay low before that cycle and take their expected values in it, then that both return low one cycle later. Every granted memory request is compared with a queue of the reads and write-backs that the model predicts, including the adjusted write data.

// File: rtl/car_pkg.sv
// Package: shared types for the chained indirect address resolver.
// Assumes: single clock domain; users compare aix_mode against the codes here.
package car_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_READ   = 2'd2,
        ST_WRITE  = 2'd3
    } car_state_e;

    localparam logic [1:0] AIX_LOW   = 2'd1;  // one incrementing window
    localparam logic [1:0] AIX_SPLIT = 2'd2;  // incrementing and decrementing windows
endpackage

// File: rtl/car_addr_calc.sv
// Module: adds the selected index register to an address field.
// Assumes: selector value 0 means "no index"; registers 1..N are packed
// in idx_flat with register k at slice (k-1).
module car_addr_calc #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned SEL_W  = 3,
    localparam int unsigned NREG  = (1 << SEL_W) - 1
) (
    input  logic [SEL_W-1:0]       sel,
    input  logic [ADDR_W-1:0]      addr_field,
    input  logic [NREG*ADDR_W-1:0] idx_flat,
    output logic [ADDR_W-1:0]      eff_addr
);
    logic [ADDR_W-1:0] idx_val [NREG+1];

    // Unpack registers; slot 0 is the constant zero offset
    generate
        for (genvar g = 0; g <= NREG; g++) begin : g_idx
            if (g == 0) begin : g_none
                assign idx_val[g] = '0;
            end else begin : g_reg
                assign idx_val[g] = idx_flat[(g-1)*ADDR_W +: ADDR_W];
            end
        end
    endgenerate

    // Modular sum of address field and selected offset
    always_comb eff_addr = addr_field + idx_val[sel];
endmodule

// File: rtl/car_autoidx.sv
// Module: classifies a pointer address against the self-modifying windows
// and produces the adjusted word (low address field +/-1, upper bits kept).
// Assumes: windows are SPAN words long and do not overlap.
module car_autoidx
    import car_pkg::*;
#(
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned WORD_W   = 36,
    parameter int unsigned SPAN     = 8,
    parameter int unsigned LOW_BASE = 8,
    parameter int unsigned INC_BASE = 16,
    parameter int unsigned DEC_BASE = 24
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [WORD_W-1:0] rdata,
    output logic              hit,
    output logic [WORD_W-1:0] new_word
);
    localparam logic [ADDR_W-1:0] LOW_LO = ADDR_W'(LOW_BASE);
    localparam logic [ADDR_W-1:0] LOW_HI = ADDR_W'(LOW_BASE + SPAN);
    localparam logic [ADDR_W-1:0] INC_LO = ADDR_W'(INC_BASE);
    localparam logic [ADDR_W-1:0] INC_HI = ADDR_W'(INC_BASE + SPAN);
    localparam logic [ADDR_W-1:0] DEC_LO = ADDR_W'(DEC_BASE);
    localparam logic [ADDR_W-1:0] DEC_HI = ADDR_W'(DEC_BASE + SPAN);

    logic do_inc, do_dec;
    logic [ADDR_W-1:0] low_field;

    // Window decode per layout
    always_comb begin
        do_inc = ((mode == AIX_LOW)   && ptr >= LOW_LO && ptr < LOW_HI) ||
                 ((mode == AIX_SPLIT) && ptr >= INC_LO && ptr < INC_HI);
        do_dec =  (mode == AIX_SPLIT) && ptr >= DEC_LO && ptr < DEC_HI;
        hit    = do_inc || do_dec;
    end

    // Adjust only the address field, preserving flag/selector/spare bits
    always_comb begin
        low_field = do_inc ? rdata[ADDR_W-1:0] + 1'b1 : rdata[ADDR_W-1:0] - 1'b1;
        new_word  = {rdata[WORD_W-1:ADDR_W], low_field};
    end
endmodule

// File: rtl/chain_addr_resolver.sv
// Module: walks a chain of indirect address words in memory until a direct
// word is found, applying index offsets at every level and self-modifying
// pointer windows. Samples irq before every decode and aborts on it.
// Assumes: memory grants a request by raising mem_rdy for one sampled edge;
// the caller keeps idx_regs and aix_mode stable during a walk.
module chain_addr_resolver
    import car_pkg::*;
#(
    parameter int unsigned WORD_W  = 36,
    parameter int unsigned ADDR_W  = 18,
    parameter int unsigned SEL_W   = 3,
    parameter int unsigned IND_POS = 35,
    parameter int unsigned SEL_POS = 18,
    parameter int unsigned SPAN    = 8,
    localparam int unsigned NREG   = (1 << SEL_W) - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [WORD_W-1:0]      first_word,
    input  logic [NREG*ADDR_W-1:0] idx_regs,
    input  logic [1:0]             aix_mode,
    input  logic                   irq,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [WORD_W-1:0]      mem_wdata,
    input  logic [WORD_W-1:0]      mem_rdata,
    input  logic                   mem_rdy,
    output logic [ADDR_W-1:0]      ea,
    output logic                   done,
    output logic                   abort
);
    car_state_e        state;
    logic [WORD_W-1:0] cur_word;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] word_addr;
    logic              aix_hit;
    logic [WORD_W-1:0] aix_word;

    car_addr_calc #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_calc (
        .sel        (cur_word[SEL_POS +: SEL_W]),
        .addr_field (cur_word[ADDR_W-1:0]),
        .idx_flat   (idx_regs),
        .eff_addr   (word_addr)
    );

    car_autoidx #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SPAN(SPAN),
        .LOW_BASE(SPAN), .INC_BASE(2*SPAN), .DEC_BASE(3*SPAN)
    ) u_aix (
        .mode     (aix_mode),
        .ptr      (ptr),
        .rdata    (mem_rdata),
        .hit      (aix_hit),
        .new_word (aix_word)
    );

    // Walk sequencer: decode, read pointer, optional write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_word <= '0;
            ptr      <= '0;
            ea       <= '0;
            done     <= 1'b0;
            abort    <= 1'b0;
        end else begin
            done  <= 1'b0;
            abort <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_word <= first_word;
                        state    <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (irq) begin
                        abort <= 1'b1;
                        state <= ST_IDLE;
                    end else if (!cur_word[IND_POS]) begin
                        ea    <= word_addr;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        ptr   <= word_addr;
                        state <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_rdy) begin
                        cur_word <= aix_hit ? aix_word : mem_rdata;
                        state    <= aix_hit ? ST_WRITE : ST_DECODE;
                    end
                end
                ST_WRITE: begin
                    if (mem_rdy) state <= ST_DECODE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port: one request per memory state
    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = ptr;
        mem_wdata = cur_word;
    end

    // R10: request held steady while not granted
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: a write-back directly follows a granted read of the same address
    assert_wb_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> ($past(mem_req && !mem_we && mem_rdy) && $stable(mem_addr)));

    // R8: abort is quiet: no done, no memory traffic
    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (!done && !mem_req));

    // R2: a completed walk leaves no request active
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R11: result changes only with its strobe
    assert_ea_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ea) |-> done);
endmodule

// File: tb/chain_addr_resolver_bench.sv
module chain_addr_resolver_bench;
    localparam int AW = 18;
    localparam int WW = 36;
    localparam int NR = 7;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic rst_n, start, irq, mem_req, mem_we, mem_rdy, done, abort;
    logic [WW-1:0] first_word, mem_wdata, mem_rdata;
    logic [NR*AW-1:0] idx_regs;
    logic [1:0] aix_mode;
    logic [AW-1:0] mem_addr, ea;

    chain_addr_resolver u_chain_addr_resolver (
        .clk(clk), .rst_n(rst_n), .start(start), .first_word(first_word),
        .idx_regs(idx_regs), .aix_mode(aix_mode), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .ea(ea), .done(done), .abort(abort)
    );

    typedef struct packed { logic we; logic [AW-1:0] a; logic [WW-1:0] d; } txn_t;

    logic [WW-1:0] mem     [0:1023];
    logic [WW-1:0] ref_mem [0:1023];
    logic [AW-1:0] idxv [1:NR];
    txn_t exp_q[$];
    int n_checks = 0, n_err = 0;
    int stall = 0, wait_cnt = 0;
    bit finished = 0;
    logic pend_we;
    logic [AW-1:0] pend_a;
    logic [WW-1:0] pend_d;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [WW-1:0] mk(bit ind, logic [2:0] sel, logic [AW-1:0] a, logic [13:0] up);
        return {ind, up, sel, a};
    endfunction

    task automatic poke(input int a, input logic [WW-1:0] w);
        mem[a] = w;
        ref_mem[a] = w;
    endtask

    // Memory model with programmable wait states; checks each grant against prediction
    always @(negedge clk) begin : p_mem
        txn_t e;
        if (mem_rdy) begin
            if (pend_we) mem[pend_a[9:0]] = pend_d;
            mem_rdy = 1'b0;
            wait_cnt = 0;
        end
        if (mem_req === 1'b1) begin
            if (wait_cnt >= stall) begin
                mem_rdy   = 1'b1;
                mem_rdata = mem[mem_addr[9:0]];
                pend_we   = mem_we;
                pend_a    = mem_addr;
                pend_d    = mem_wdata;
                if (exp_q.size() == 0) begin
                    chk("R4", "unexpected request", 64'(mem_addr), 64'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R4", "request kind", 64'(mem_we), 64'(e.we));
                    chk("R4", "request addr", 64'(mem_addr), 64'(e.a));
                    if (e.we) chk("R7", "write-back data", 64'(mem_wdata), 64'(e.d));
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    function automatic bit in_win(logic [AW-1:0] a, output bit dec);
        dec = 0;
        if (aix_mode == 2'd1 && a >= 8 && a < 16) return 1;
        if (aix_mode == 2'd2 && a >= 16 && a < 24) return 1;
        if (aix_mode == 2'd2 && a >= 24 && a < 32) begin dec = 1; return 1; end
        return 0;
    endfunction

    // Behavioural model: walk the chain on ref_mem, accumulating cycle time
    task automatic predict(input logic [WW-1:0] w0, input int irq_at,
                           output int t_end, output bit ab, output logic [AW-1:0] ea_e);
        logic [WW-1:0] w = w0;
        int t = 1;
        ab = 0; ea_e = '0; t_end = -1;
        for (int lvl = 0; lvl < 200; lvl++) begin
            logic [AW-1:0] a;
            logic [WW-1:0] rd;
            bit dec;
            if (irq_at >= 0 && irq_at < t) begin ab = 1; t_end = t; return; end
            a = w[17:0] + ((w[20:18] == 3'd0) ? 18'd0 : idxv[w[20:18]]);
            if (!w[35]) begin ea_e = a; t_end = t; return; end
            exp_q.push_back({1'b0, a, 36'd0});
            rd = ref_mem[a[9:0]];
            t += 1 + stall;
            if (in_win(a, dec)) begin
                rd = {rd[35:18], dec ? rd[17:0] - 18'd1 : rd[17:0] + 18'd1};
                ref_mem[a[9:0]] = rd;
                exp_q.push_back({1'b1, a, rd});
                t += 1 + stall;
            end
            w = rd;
            t += 1;
        end
    endtask

    task automatic run(input string tag, input logic [WW-1:0] w0, input int irq_at, input int s);
        int t_end;
        bit ab;
        logic [AW-1:0] ea_e, ea_prev;
        stall = s;
        for (int k = 1; k <= NR; k++) idx_regs[(k-1)*AW +: AW] = idxv[k];
        predict(w0, irq_at, t_end, ab, ea_e);
        ea_prev = ea;
        @(negedge clk);
        first_word = w0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (irq_at == 0) irq = 1'b1;
        for (int c = 1; c <= t_end; c++) begin
            @(negedge clk);
            if (c == irq_at) irq = 1'b1;
            if (c < t_end) begin
                chk(tag, "done before due", 64'(done), 64'h0);
                chk(tag, "abort before due", 64'(abort), 64'h0);
                chk("R11", "ea held during walk", 64'(ea), 64'(ea_prev));
            end
        end
        chk(tag, "done at due cycle", 64'(done), 64'(!ab));
        chk(ab ? "R8" : tag, "abort at due cycle", 64'(abort), 64'(ab));
        if (!ab) chk(tag, "effective address", 64'(ea), 64'(ea_e));
        irq = 1'b0;
        @(negedge clk);
        chk("R11", "done is one pulse", 64'(done), 64'h0);
        chk("R11", "abort is one pulse", 64'(abort), 64'h0);
        chk("R8", "no request after end", 64'(mem_req), 64'h0);
        chk(tag, "all predicted requests seen", 64'(exp_q.size()), 64'h0);
        exp_q.delete();
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; irq = 1'b0; mem_rdy = 1'b0; aix_mode = 2'd0;
        first_word = '0; idx_regs = '0; mem_rdata = '0;
        pend_we = 1'b0; pend_a = '0; pend_d = '0;
        for (int i = 0; i < 1024; i++) begin mem[i] = '0; ref_mem[i] = '0; end
        idxv[1] = 18'h00100; idxv[2] = 18'h00020; idxv[3] = 18'h01000; idxv[4] = 18'h3FFFF;
        idxv[5] = 18'h00007; idxv[6] = 18'h00040; idxv[7] = 18'h00002;
        repeat (3) @(negedge clk);
        chk("R11", "reset done", 64'(done), 64'h0);
        chk("R11", "reset abort", 64'(abort), 64'h0);
        chk("R10", "reset request", 64'(mem_req), 64'h0);
        rst_n = 1'b1;

        // R1/R2: direct words, selector 0 and wrapping index add
        run("R2", mk(0, 3'd0, 18'h12345, 14'h0), -1, 0);
        run("R1", mk(0, 3'd2, 18'h3FFF0, 14'h0), -1, 0);
        run("R1", mk(0, 3'd4, 18'h00005, 14'h3FFF), -1, 0);

        // R3/R4: three-level chain with index at every level; then with wait states
        poke(256, mk(1, 3'd5, 18'd300, 14'h0));
        poke(307, mk(0, 3'd3, 18'h00055, 14'h0));
        run("R3", mk(1, 3'd1, 18'd0, 14'h0), -1, 0);
        run("R10", mk(1, 3'd1, 18'd0, 14'h0), -1, 2);

        // R5/R7: low window increments, upper bits kept, repeat sees new value
        aix_mode = 2'd1;
        poke(9, mk(0, 3'd0, 18'd500, 14'h1234));
        run("R5", mk(1, 3'd0, 18'd9, 14'h0), -1, 0);
        run("R5", mk(1, 3'd0, 18'd9, 14'h0), -1, 1);
        // R7: final address inside the window is not touched
        run("R7", mk(0, 3'd0, 18'd9, 14'h0), -1, 0);

        // R6: no window in modes 0 and 3; low window is plain in mode 2
        aix_mode = 2'd0;
        run("R6", mk(1, 3'd0, 18'd9, 14'h0), -1, 0);
        aix_mode = 2'd3;
        run("R6", mk(1, 3'd0, 18'd9, 14'h0), -1, 0);
        aix_mode = 2'd2;
        run("R6", mk(1, 3'd0, 18'd9, 14'h0), -1, 0);
        // R6/R7: increment location chains into decrement location that wraps
        poke(17, mk(1, 3'd0, 18'd24, 14'h0));
        poke(25, mk(0, 3'd0, 18'd0, 14'h2AAA));
        run("R7", mk(1, 3'd0, 18'd17, 14'h0), -1, 0);

        // R8: interrupt before first decode, and a self-referencing chain
        run("R8", mk(1, 3'd0, 18'd256, 14'h0), 0, 0);
        poke(600, mk(1, 3'd0, 18'd600, 14'h0));
        run("R8", mk(1, 3'd0, 18'd600, 14'h0), 6, 0);
        run("R8", mk(1, 3'd0, 18'd600, 14'h0), 10, 1);

        // R9: abort after a write-back; restart observes the kept write
        aix_mode = 2'd1;
        poke(10, mk(0, 3'd0, 18'd700, 14'h0));
        run("R9", mk(1, 3'd0, 18'd10, 14'h0), 3, 0);
        run("R9", mk(1, 3'd0, 18'd10, 14'h0), -1, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule